// File: doc/BRIEF.md
# Quad-Channel TDM Frame Sync Generator

This block provides the slot timing for a four-channel voice codec that shares a 32-slot, 256-bit TDM frame with seven other identical devices. It runs from the fixed 2.048 MHz bit clock, so every clock is one bit time and one frame spans 256 clocks. A single global frame-start pulse aligns a frame position counter. From that counter the block produces one frame-sync strobe per local channel, drives the shared serial output line only during its own slots, and collects the bits of the incoming serial line into one receive byte per channel.

A 3-bit base slot selects which of the eight slot groups the device owns. Channel c uses slot base+8c, so the four channels sit exactly a quarter-frame (64 clocks) apart and eight devices with distinct bases fill the whole frame. Local channels are always numbered 0 to 3, whatever slot they fall in. Each channel's transmit byte is copied into a holding buffer when that channel's sync fires and is shifted out MSB first in the following eight clocks. The serial line is released at all other times so that the other devices can drive it. Slot assignment is fixed. There is no dynamic allocation.

Top module: `tdm_quad_sync`

## Requirements
- R1: After reset, and until the first frameStart, fs, pcmOe and rxValid stay low and rxSamples holds zero.
- R2: The clock after a frameStart cycle carries frame bit 0. Slot s occupies frame bits 8s to 8s+7.
- R3: fs[c] is high for exactly one clock, in the clock before the first bit of slot base+8c. Each channel gets one pulse per frame, and consecutive channels are 64 clocks apart.
- R4: During each owned slot, pcmOe is high for 8 clocks and pcmOut carries that channel's transmit byte MSB first. Outside owned slots pcmOe is low. Channel c's transmit byte is txSamples[8c+7:8c].
- R5: The transmit byte is captured in the clock where fs[c] is high. Changes to txSamples after that clock do not alter the byte sent in that slot.
- R6: pcmIn is sampled MSB first during owned slots. In the clock after the eighth bit, rxSamples[8c+7:8c] holds the byte and rxValid[c] pulses for one clock. pcmIn outside owned slots has no effect.
- R7: A new baseSlot value is taken only in a frameStart clock. Changes between frameStarts do not move the windows of the current frame.
- R8: Without a new frameStart, the frame repeats every 256 clocks with the same slot positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Global frame alignment pulse, one clock before frame bit 0 |
| baseSlot | input | 3 | Slot group owned by this device |
| pcmIn | input | 1 | Shared serial receive line |
| txSamples | input | 32 | Four transmit bytes, channel c at bits 8c+7:8c |
| fs | output | 4 | Per-channel frame-sync strobes |
| pcmOut | output | 1 | Serial transmit data |
| pcmOe | output | 1 | Drive enable for pcmOut |
| rxSamples | output | 32 | Four received bytes, channel c at bits 8c+7:8c |
| rxValid | output | 4 | One-clock pulse per channel when its byte is updated |

## Verification
Frames are run with bases 0, 3, 5 and 7, which place the windows at the very start of the frame, in the middle, and at the final bit where the last receive byte completes after the next frame-start. Each frame uses distinct transmit and receive bytes per channel, so swapped channels or reversed bit order give wrong values. The bits outside the windows are driven to toggling junk, so a wrong window exposes itself in the receive data. Further frames change baseSlot in the middle of a frame, corrupt txSamples right after each sync, and omit frameStart. These separate the base-latch rule, the transmit buffer capture and the free-running period. Every event is matched against the expected cycle, so an off-by-one in the sync or the valid pulse shows up as a mismatch.

// File: rtl/tdm_quad_pkg.sv
package tdm_quad_pkg;
  localparam int CH_NUM    = 4;
  localparam int SAMPLE_W  = 8;
  localparam int SLOT_NUM  = 32;

  localparam int FRAME_LEN = SLOT_NUM * SAMPLE_W;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int BIT_W     = $clog2(SAMPLE_W);
  localparam int CH_W      = $clog2(CH_NUM);
  localparam int GROUP_NUM = SLOT_NUM / CH_NUM;
  localparam int BASE_W    = $clog2(GROUP_NUM);
  localparam int FLAT_W    = CH_NUM * SAMPLE_W;

  typedef struct packed {
    logic [CH_NUM-1:0] fsPulse;
    logic              inWin;
    logic [CH_W-1:0]   chan;
    logic [BIT_W-1:0]  bitIdx;
    logic              lastBit;
  } strobe_t;
endpackage

// File: rtl/tdm_quad_ctrl.sv
module tdm_quad_ctrl
  import tdm_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [BASE_W-1:0] baseSlot,
  output strobe_t           strb
);
  logic [POS_W-1:0]  pos;
  logic [BASE_W-1:0] activeBase;
  logic              running;

  logic [POS_W-1:0]  nextPos;
  logic [BASE_W-1:0] nextBase;
  logic              nextRun;

  always_comb begin
    nextPos  = frameStart ? '0 : pos + POS_W'(1);
    nextBase = frameStart ? baseSlot : activeBase;
    nextRun  = running | frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos        <= '0;
      activeBase <= '0;
      running    <= 1'b0;
    end else if (frameStart) begin
      pos        <= '0;
      activeBase <= baseSlot;
      running    <= 1'b1;
    end else if (running) begin
      pos <= pos + POS_W'(1);
    end
  end

  // One sync per channel, raised one clock ahead of its window
  for (genvar c = 0; c < CH_NUM; c++) begin : g_fs
    always_comb begin
      strb.fsPulse[c] = nextRun
                     && (nextPos[POS_W-1 -: CH_W] == CH_W'(c))
                     && (nextPos[BIT_W +: BASE_W] == nextBase)
                     && (nextPos[BIT_W-1:0] == '0);
    end
  end

  always_comb begin
    strb.inWin   = running && (pos[BIT_W +: BASE_W] == activeBase);
    strb.chan    = pos[POS_W-1 -: CH_W];
    strb.bitIdx  = pos[BIT_W-1:0];
    strb.lastBit = strb.inWin && (pos[BIT_W-1:0] == BIT_W'(SAMPLE_W-1));
  end

  // R3: never two syncs at once
  p_fs_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.fsPulse));

  // R3: a sync is followed by bit 0 of an owned window
  p_fs_opens_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.fsPulse) |=> (strb.inWin && strb.bitIdx == '0));

  // R7: base only moves on a frame start
  p_base_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeBase));
endmodule

// File: rtl/tdm_quad_data.sv
module tdm_quad_data
  import tdm_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              pcmIn,
  input  logic [FLAT_W-1:0] txFlat,
  output logic              pcmOut,
  output logic              pcmOe,
  output logic [FLAT_W-1:0] rxFlat,
  output logic [CH_NUM-1:0] rxValid
);
  logic [SAMPLE_W-1:0] txBuf [CH_NUM];
  logic [SAMPLE_W-2:0] rxShift;
  logic [SAMPLE_W-1:0] curByte;
  logic [BIT_W-1:0]    bitSel;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txBuf[c]                       <= '0;
        rxFlat[c*SAMPLE_W +: SAMPLE_W] <= '0;
        rxValid[c]                     <= 1'b0;
      end else begin
        if (strb.fsPulse[c])
          txBuf[c] <= txFlat[c*SAMPLE_W +: SAMPLE_W];
        rxValid[c] <= strb.lastBit && (strb.chan == CH_W'(c));
        if (strb.lastBit && (strb.chan == CH_W'(c)))
          rxFlat[c*SAMPLE_W +: SAMPLE_W] <= {rxShift, pcmIn};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rxShift <= '0;
    else if (strb.inWin)
      rxShift <= {rxShift[SAMPLE_W-3:0], pcmIn};
  end

  always_comb begin
    curByte = txBuf[strb.chan];
    bitSel  = BIT_W'(SAMPLE_W-1) - strb.bitIdx;
    pcmOe   = strb.inWin;
    pcmOut  = strb.inWin ? curByte[bitSel] : 1'b0;
  end

  // R6: at most one channel completes per clock
  p_rxvalid_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxValid));

  // R6: a completed byte follows a driven window bit
  p_rxvalid_after_win_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|rxValid) |-> $past(strb.inWin));
endmodule

// File: rtl/tdm_quad_sync.sv
module tdm_quad_sync
  import tdm_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [BASE_W-1:0] baseSlot,
  input  logic              pcmIn,
  input  logic [FLAT_W-1:0] txSamples,
  output logic [CH_NUM-1:0] fs,
  output logic              pcmOut,
  output logic              pcmOe,
  output logic [FLAT_W-1:0] rxSamples,
  output logic [CH_NUM-1:0] rxValid
);
  strobe_t strb;

  tdm_quad_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .baseSlot   (baseSlot),
    .strb       (strb)
  );

  tdm_quad_data i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pcmIn   (pcmIn),
    .txFlat  (txSamples),
    .pcmOut  (pcmOut),
    .pcmOe   (pcmOe),
    .rxFlat  (rxSamples),
    .rxValid (rxValid)
  );

  assign fs = strb.fsPulse;

  // R4: the line is driven in the clock after any sync
  p_fs_then_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|fs) |=> pcmOe);
endmodule

// File: tb/test_tdm_quad_sync.sv
module test_tdm_quad_sync;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [2:0]  baseSlot = 3'd0;
  logic        pcmIn = 1'b0;
  logic [31:0] txSamples = '0;
  logic [3:0]  fs;
  logic        pcmOut;
  logic        pcmOe;
  logic [31:0] rxSamples;
  logic [3:0]  rxValid;

  tdm_quad_sync i_tdm_quad_sync (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .baseSlot(baseSlot),
    .pcmIn(pcmIn), .txSamples(txSamples), .fs(fs), .pcmOut(pcmOut),
    .pcmOe(pcmOe), .rxSamples(rxSamples), .rxValid(rxValid)
  );

  always #5 clk = ~clk;

  localparam int K_FS = 0, K_TX = 1, K_RX = 2;
  typedef struct {
    int          kind;
    int          chan;
    longint      cyc;
    logic [7:0]  val;
    string       tag;
  } ev_t;

  ev_t    expQ[$];
  longint cyc = 0;
  int     checks = 0;
  int     errors = 0;
  bit     monOn = 1'b0;
  bit     done = 1'b0;
  logic   carryBit = 1'b0;

  int         txCnt = 0;
  longint     txStart = 0;
  logic [7:0] txByte = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string kname(int k);
    return (k == K_FS) ? "sync" : (k == K_TX) ? "txbyte" : "rxbyte";
  endfunction

  task automatic expect_ev(int kind, int chan, longint at, logic [7:0] v, string tag);
    ev_t e;
    e.kind = kind; e.chan = chan; e.cyc = at; e.val = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic observe(int kind, int chan, longint at, logic [7:0] v);
    int hit = -1;
    foreach (expQ[i])
      if (hit < 0 && expQ[i].kind == kind && expQ[i].cyc == at &&
          (chan < 0 || expQ[i].chan == chan))
        hit = i;
    checks++;
    if (hit < 0) begin
      errors++;
      $display("FAIL %s: unexpected %s chan %0d at cycle %0d value %02h, expected none",
               (kind == K_FS) ? "R3" : (kind == K_TX) ? "R4" : "R6",
               kname(kind), chan, at, v);
    end else begin
      if (kind != K_FS && expQ[hit].val !== v) begin
        errors++;
        $display("FAIL %s: %s chan %0d at cycle %0d actual %02h expected %02h",
                 expQ[hit].tag, kname(kind), expQ[hit].chan, at, v, expQ[hit].val);
      end
      expQ.delete(hit);
    end
  endtask

  // Monitor: turns port activity into events and matches them
  always @(negedge clk) begin
    if (monOn) begin
      for (int c = 0; c < 4; c++)
        if (fs[c]) observe(K_FS, c, cyc, 8'h00);
      if (pcmOe) begin
        if (txCnt == 0) txStart = cyc;
        txByte = {txByte[6:0], pcmOut};
        txCnt++;
        if (txCnt == 8) begin
          observe(K_TX, -1, txStart, txByte);
          txCnt = 0;
        end
      end else if (txCnt != 0) begin
        checks++; errors++;
        $display("FAIL R4: window cut at cycle %0d after %0d bits, expected 8", cyc, txCnt);
        txCnt = 0;
      end
      for (int c = 0; c < 4; c++)
        if (rxValid[c]) observe(K_RX, c, cyc, rxSamples[8*c +: 8]);
    end
  end

  task automatic check_val(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic in_bit(logic [2:0] b, logic [31:0] rx, int p);
    if (p[5:3] == b) return rx[8*p[7:6] + 7 - p[2:0]];
    return ~p[0];
  endfunction

  // Driver: one 256-clock frame; cycle k carries frame bit k-1
  task automatic run_frame(logic [2:0] b, logic [31:0] tx, logic [31:0] rx,
                           logic [2:0] midBase, bit doStart, bit corrupt, string tag);
    longint f;
    @(posedge clk); #1;
    f = cyc;
    frameStart = doStart;
    baseSlot   = doStart ? b : midBase;
    txSamples  = tx;
    pcmIn      = carryBit;
    for (int c = 0; c < 4; c++) begin
      int s = b + 8 * c;
      expect_ev(K_FS, c, f + 8 * s, 8'h00, tag);
      expect_ev(K_TX, c, f + 8 * s + 1, tx[8*c +: 8], tag);
      expect_ev(K_RX, c, f + 8 * s + 9, rx[8*c +: 8], tag);
    end
    for (int k = 1; k < 256; k++) begin
      int p = k - 1;
      @(posedge clk); #1;
      frameStart = 1'b0;
      baseSlot   = midBase;
      pcmIn      = in_bit(b, rx, p);
      if (corrupt && p[5:3] == b && p[2:0] == 0)
        txSamples[8*p[7:6] +: 8] = ~tx[8*p[7:6] +: 8];
    end
    carryBit = in_bit(b, rx, 255);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      frameStart = 1'b0;
      pcmIn = (k == 0) ? carryBit : k[0];
    end
    carryBit = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    @(negedge clk);
    check_val("R1", "fs in reset", fs, 0);
    check_val("R1", "pcmOe in reset", pcmOe, 0);
    check_val("R1", "rxValid in reset", rxValid, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    monOn = 1'b1;
    // R1: no activity before the first frame start, even with pcmIn toggling
    idle(40);
    @(negedge clk);
    check_val("R1", "rxSamples before start", rxSamples, 0);
    check_val("R1", "pcmOe before start", pcmOe, 0);

    // R2 R3 R4 R6: base 0, windows at frame start; baseSlot moves mid-frame (R7)
    run_frame(3'd0, 32'h5AC3_0F81, 32'h3C96_E117, 3'd3, 1'b1, 1'b0, "R7");
    // R2 R3 R4 R6: base 3, middle of the group
    run_frame(3'd3, 32'hF00D_7E42, 32'h81A5_5A18, 3'd6, 1'b1, 1'b0, "R2");
    // R8: no frame start, base 3 kept
    run_frame(3'd3, 32'h1248_9BDE, 32'hC0FF_EE11, 3'd1, 1'b0, 1'b0, "R8");
    // R5: tx bytes altered right after each sync; base 7 ends on the last bit
    run_frame(3'd7, 32'hA1B2_C3D4, 32'h0180_FE7F, 3'd7, 1'b1, 1'b1, "R5");
    // R3 R6: base 5, received byte completes across the frame boundary above
    run_frame(3'd5, 32'h00FF_6699, 32'hFF00_9966, 3'd5, 1'b1, 1'b0, "R6");
    idle(30);

    // all expected events seen
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d expected events missing, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2: watchdog expired at cycle %0d, expected completion", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule